// File: doc/BRIEF.md
# Divider-Tap Periodic Rate Selector

This block takes the stage outputs of a 15-stage binary prescaler and uses a 4-bit rate code to pick one of them. The chosen stage can drive a square-wave pin and a periodic event flag, and each of these has its own enable. One code value turns both off. The flag is set on every rising edge of the chosen stage and stays set until a read strobe from the host clears it. An interrupt request is raised while the flag is set and the interrupt enable is high.

The prescaler is assumed to run from a 32.768 kHz source, so stage i toggles at 32768/2^(i+1) Hz. The stage outputs are taken to be synchronous to `clk`. The block does not build the prescaler, and it holds none of the host registers. The rate code and both enables come in as plain inputs.

Top module: `rate_tap_sel`

## Requirements
- R1: Rate code 1 selects stage 6 (256 Hz) and code 2 selects stage 7 (128 Hz). Codes 3 to 15 select stage (code - 2), which runs from 8.192 kHz at code 3 down to 2 Hz at code 15. With `sqw_en` high, `sqw_out` equals the level of the selected stage.
- R2: Rate code 0 selects no stage. `sqw_out` is low, and no stage edge sets `pflag`.
- R3: While `sqw_en` is low, `sqw_out` is low whatever the rate code and the stage levels.
- R4: `sqw_out` follows the selected stage combinationally in the same cycle, and it keeps doing so while `rst_n` is low.
- R5: A rising edge on the selected stage sets `pflag` at the next clock edge, whatever the value of `pint_en`. A rising edge here means the stage is high in this cycle and was low in the previous cycle.
- R6: `flag_rd_clr` clears `pflag` at the next clock edge. If a rising edge occurs in the same cycle, the set wins. With neither a rising edge nor a clear, `pflag` holds its value.
- R7: `irq` is high exactly when `pflag` and `pint_en` are both high, in the same cycle.
- R8: Changing the rate code does not set `pflag` by itself. A new stage that was already high in the previous cycle produces no edge.
- R9: While `rst_n` is low, and for the cycles until the internally synchronized release, `pflag` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| div_taps | input | 15 | Prescaler stage outputs, bit i = stage i |
| rate_code | input | 4 | Rate code, 0 = off |
| sqw_en | input | 1 | Square-wave pin enable |
| pint_en | input | 1 | Periodic interrupt enable |
| flag_rd_clr | input | 1 | One-cycle strobe that clears the periodic flag on a read |
| sqw_out | output | 1 | Square-wave output |
| pflag | output | 1 | Periodic event flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the stage inputs change only in step with `clk`. They also assume that a rising edge is judged against the same stage's level one cycle earlier, as that level is seen after the synchronized reset release. The stimulus drives every input at the falling edge and flips random stage bits from cycle to cycle. It does not model a real prescaler, so edges arrive far more often than real hardware would produce them. The rate code and both enables change at random points, often in the same cycle as a stage edge or a clear strobe. Before reset is released, the stage inputs are brought back to zero so that the first cycles after release show no spurious edges.

// File: rtl/rts_pkg.sv
package rts_pkg;
  localparam int RTS_STAGES   = 15;
  localparam int RTS_CODE_W   = 4;
  localparam int RTS_SLOW_ST  = 6;  // stage for code 1
  localparam int RTS_FAST_CD  = 3;  // first code of the fast run
  localparam int RTS_FAST_OFS = 2;  // stage = code - offset in the fast run

  // Stage index for a rate code; -1 means no stage (output off)
  function automatic int rts_stage(input int code);
    if (code <= 0)
      return -1;
    else if (code < RTS_FAST_CD)
      return RTS_SLOW_ST + code - 1;
    else
      return code - RTS_FAST_OFS;
  endfunction
endpackage

// File: rtl/rts_reset_sync.sv
module rts_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sync_q <= 2'b00;
    else
      sync_q <= sync_d;
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/rts_edge_bank.sv
module rts_edge_bank #(
  parameter int NUM_STAGES = 15
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_STAGES-1:0] taps,
  output logic [NUM_STAGES-1:0] rise
);
  logic [NUM_STAGES-1:0] hist_q;
  logic [NUM_STAGES-1:0] hist_d;

  always_comb begin
    hist_d = taps;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hist_q <= '0;
    else
      hist_q <= hist_d;
  end

  // One rise detector per stage, each against its own history
  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_rise
    assign rise[g] = taps[g] & ~hist_q[g];
  end
endmodule

// File: rtl/rts_tap_mux.sv
module rts_tap_mux #(
  parameter int NUM_STAGES = 15,
  parameter int SEL_W      = 4
) (
  input  logic [NUM_STAGES-1:0] taps,
  input  logic [NUM_STAGES-1:0] rise,
  input  logic [SEL_W-1:0]      code,
  output logic                  active,
  output logic                  level,
  output logic                  edge_hit
);
  import rts_pkg::*;
  localparam int IDX_W = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1;

  int              st;
  logic [IDX_W-1:0] idx;

  always_comb begin
    st       = rts_stage(int'(code));
    active   = (st >= 0) && (st < NUM_STAGES);
    idx      = st[IDX_W-1:0];
    level    = 1'b0;
    edge_hit = 1'b0;
    if (active) begin
      level    = taps[idx];
      edge_hit = rise[idx];
    end
  end
endmodule

// File: rtl/rts_flag_reg.sv
module rts_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = set | clr;
    flag_d  = set | (flag_q & ~clr);  // set wins over clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_q <= 1'b0;
    else if (flag_en)
      flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/rate_tap_sel.sv
module rate_tap_sel #(
  parameter int NUM_STAGES = rts_pkg::RTS_STAGES,
  parameter int SEL_W      = rts_pkg::RTS_CODE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_STAGES-1:0] div_taps,
  input  logic [SEL_W-1:0]      rate_code,
  input  logic                  sqw_en,
  input  logic                  pint_en,
  input  logic                  flag_rd_clr,
  output logic                  sqw_out,
  output logic                  pflag,
  output logic                  irq
);
  logic                  rst_n_s;
  logic [NUM_STAGES-1:0] rise_vec;
  logic                  sel_active;
  logic                  sel_level;
  logic                  sel_edge;

  rts_reset_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  rts_edge_bank #(.NUM_STAGES(NUM_STAGES)) u_edges (
    .clk   (clk),
    .rst_n (rst_n_s),
    .taps  (div_taps),
    .rise  (rise_vec)
  );

  rts_tap_mux #(.NUM_STAGES(NUM_STAGES), .SEL_W(SEL_W)) u_mux (
    .taps     (div_taps),
    .rise     (rise_vec),
    .code     (rate_code),
    .active   (sel_active),
    .level    (sel_level),
    .edge_hit (sel_edge)
  );

  rts_flag_reg u_flag (
    .clk   (clk),
    .rst_n (rst_n_s),
    .set   (sel_edge),
    .clr   (flag_rd_clr),
    .flag  (pflag)
  );

  assign sqw_out = sel_active & sel_level & sqw_en;
  assign irq     = pflag & pint_en;
endmodule

// File: rtl/rate_tap_sel_chk.sv
module rate_tap_sel_chk #(
  parameter int NUM_STAGES = 15,
  parameter int SEL_W      = 4
) (
  input logic                  clk,
  input logic                  rst_n_s,
  input logic [NUM_STAGES-1:0] div_taps,
  input logic [SEL_W-1:0]      rate_code,
  input logic                  sqw_en,
  input logic                  pint_en,
  input logic                  flag_rd_clr,
  input logic                  sqw_out,
  input logic                  pflag,
  input logic                  irq
);
  import rts_pkg::*;

  logic [NUM_STAGES-1:0] seen_q;
  logic                  c_rise;
  int                    c_st;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)
      seen_q <= '0;
    else
      seen_q <= div_taps;
  end

  always_comb begin
    c_st   = rts_stage(int'(rate_code));
    c_rise = 1'b0;
    if (c_st >= 0 && c_st < NUM_STAGES)
      c_rise = div_taps[c_st] && !seen_q[c_st];
  end

  AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n_s)
    c_rise |=> pflag);  // R5
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (pflag && !flag_rd_clr) |=> pflag);  // R6
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (flag_rd_clr && !c_rise) |=> !pflag);  // R6
  AST_OFF_NO_SET: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rate_code == '0 && !pflag) |=> !pflag);  // R2
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!c_rise && !pflag) |=> !pflag);  // R8
  AST_SQW_GATED: assert property (@(posedge clk)
    (!sqw_en || rate_code == '0) |-> !sqw_out);  // R3
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk)
    !pint_en |-> !irq);  // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n_s |-> (!pflag && !irq));  // R9
endmodule

bind rate_tap_sel rate_tap_sel_chk #(.NUM_STAGES(NUM_STAGES), .SEL_W(SEL_W)) u_chk (
  .clk         (clk),
  .rst_n_s     (rst_n_s),
  .div_taps    (div_taps),
  .rate_code   (rate_code),
  .sqw_en      (sqw_en),
  .pint_en     (pint_en),
  .flag_rd_clr (flag_rd_clr),
  .sqw_out     (sqw_out),
  .pflag       (pflag),
  .irq         (irq)
);

// File: tb/rate_tap_sel_bench.sv
module rate_tap_sel_bench;
  localparam int N = 15;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] taps;
  logic [3:0]   rs;
  logic         sqwe;
  logic         pie;
  logic         clr;
  logic         sqw_out;
  logic         pflag;
  logic         irq;

  int n_chk;
  int n_bad;
  logic [N-1:0] m_prev;
  logic         m_flag;
  logic         m_next;

  rate_tap_sel u_rate_tap_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .div_taps    (taps),
    .rate_code   (rs),
    .sqw_en      (sqwe),
    .pint_en     (pie),
    .flag_rd_clr (clr),
    .sqw_out     (sqw_out),
    .pflag       (pflag),
    .irq         (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Expected stage per code, written from the requirement table (R1)
  function automatic int exp_stage(input logic [3:0] c);
    case (c)
      4'd0:    return -1;
      4'd1:    return 6;
      4'd2:    return 7;
      default: return int'(c) - 2;
    endcase
  endfunction

  function automatic logic exp_sqw(input logic [N-1:0] t, input logic [3:0] c, input logic en);
    int s;
    s = exp_stage(c);
    if (s < 0 || !en) return 1'b0;
    return t[s];
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b (rs=%0d taps=%h)", req, act, exp, rs, taps);
    end
  endtask

  // Drive one cycle at the falling edge, check, then advance the model
  task automatic step(input logic [N-1:0] t, input logic [3:0] c,
                      input logic se, input logic pe, input logic cl);
    int s;
    @(negedge clk);
    taps = t; rs = c; sqwe = se; pie = pe; clr = cl;
    #2;
    chk("R1", sqw_out, exp_sqw(taps, rs, sqwe));
    chk("R5", pflag, m_flag);
    chk("R7", irq, m_flag & pie);
    s = exp_stage(rs);
    m_next = ((s >= 0) && taps[s] && !m_prev[s]) ? 1'b1 : (clr ? 1'b0 : m_flag);
    @(posedge clk);
    #1;
    m_flag = m_next;
    m_prev = taps;
  endtask

  initial begin
    int timeout;
    timeout = 0;
    while (timeout < 150000) begin
      @(posedge clk);
      timeout++;
    end
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [N-1:0] t;
    logic [3:0]   c;
    void'($urandom(32'd2468));
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; taps = '0; rs = 4'd3; sqwe = 1'b1; pie = 1'b1; clr = 1'b0;
    m_prev = '0; m_flag = 1'b0;

    // Reset state and square wave during reset
    repeat (3) @(negedge clk);
    taps = 15'h0002;
    #2;
    chk("R9", pflag, 1'b0);
    chk("R9", irq, 1'b0);
    chk("R4", sqw_out, 1'b1);
    @(negedge clk);
    taps = 15'h7FFD;
    #2;
    chk("R4", sqw_out, 1'b0);
    @(posedge clk);
    #1;
    chk("R9", pflag, 1'b0);
    @(negedge clk);
    taps = '0;
    rst_n = 1'b1;
    repeat (4) step('0, 4'd3, 1'b1, 1'b1, 1'b0);

    // R1: every code reaches its stage, level high then low
    for (int k = 1; k < 16; k++) begin
      t = '0;
      t[exp_stage(4'(k))] = 1'b1;
      step(t, 4'(k), 1'b1, 1'b0, 1'b1);
      chk("R1", sqw_out, 1'b1);
      step(~t, 4'(k), 1'b1, 1'b0, 1'b1);
      chk("R1", sqw_out, 1'b0);
    end
    step('0, 4'd4, 1'b1, 1'b1, 1'b1);

    // R2: code 0, all stages rising, nothing happens
    step('1, 4'd0, 1'b1, 1'b1, 1'b0);
    chk("R2", sqw_out, 1'b0);
    step('0, 4'd0, 1'b1, 1'b1, 1'b0);
    chk("R2", pflag, 1'b0);

    // R5: edge sets flag with interrupt disabled; R7 irq then follows enable
    step(15'h0004, 4'd4, 1'b1, 1'b0, 1'b0);
    step(15'h0004, 4'd4, 1'b1, 1'b0, 1'b0);
    chk("R5", pflag, 1'b1);
    chk("R7", irq, 1'b0);
    step(15'h0004, 4'd4, 1'b1, 1'b1, 1'b0);
    chk("R7", irq, 1'b1);

    // R3: square wave off while enable low
    step(15'h0004, 4'd4, 1'b0, 1'b1, 1'b0);
    chk("R3", sqw_out, 1'b0);

    // R6: clear, then set wins over clear
    step('0, 4'd4, 1'b1, 1'b1, 1'b1);
    step('0, 4'd4, 1'b1, 1'b1, 1'b0);
    chk("R6", pflag, 1'b0);
    step(15'h0004, 4'd4, 1'b1, 1'b1, 1'b1);
    step(15'h0004, 4'd4, 1'b1, 1'b1, 1'b0);
    chk("R6", pflag, 1'b1);
    step(15'h0004, 4'd4, 1'b1, 1'b1, 1'b1);

    // R8: switch to a stage that was already high: no flag
    step(15'h0001 << 9, 4'd5, 1'b1, 1'b1, 1'b0);
    step(15'h0001 << 9, 4'd5, 1'b1, 1'b1, 1'b0);
    step(15'h0001 << 9, 4'd11, 1'b1, 1'b1, 1'b0);
    step(15'h0001 << 9, 4'd11, 1'b1, 1'b1, 1'b0);
    chk("R8", pflag, 1'b0);

    // Random phase
    c = 4'd3;
    t = '0;
    for (int i = 0; i < 4000; i++) begin
      t = t ^ (N'($urandom) & N'($urandom));
      if ($urandom % 16 == 0) c = 4'($urandom);
      step(t, c, ($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 8) == 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule